// File: doc/BRIEF.md
# Four-Way Set-Associative Cache Storage Array

This block is the storage and lookup half of a small data cache for a 12-bit byte-addressed system. It holds 1 KiB as four ways of sixteen sets, each set entry holding a 16-byte line, a tag and a valid bit. On every cycle it compares the tags of all four ways at the indexed set against the address tag. It reports whether any valid line matched and which way matched.

An external sequencer drives three controls: read enable, write enable and memory-ready. Together they pick one of three operations. A read-out latches one byte of the hitting line into the processor data register. A byte write stores one processor byte into the hitting line. A line fill stores a whole 128-bit block, taken from the memory side, together with the address tag. A fill that misses lands in the way named by a two-bit counter that advances on every clock, which gives a cheap pseudo-random replacement. A fill that hits refreshes the way that already holds the tag.

Top module: `sa4_cache_array`

## Requirements
- R1: The address splits as byte offset = addr[3:0], set index = addr[7:4], tag = addr[11:8]. A stored line is found only at its own index and only with its own tag.
- R2: `hit` is 1 in the same cycle when a valid line at the indexed set holds the address tag. `hit_way` then gives that way number (0 to 3), and it is 0 when `hit` is 0. Both are combinational from `addr` and the stored state.
- R3: Reset clears every valid bit, so every lookup misses after reset until a fill.
- R4: A read-out (rd_en=1, wr_en=0, mem_rdy=0) that hits loads `rd_data` at the next rising edge with byte `off` of the hitting line. Byte k of a line is bits [8k+7:8k] of the fill word, so offset 1 is the second byte from the least significant end.
- R5: `rd_data` is 0 after reset. It keeps its value on every cycle that is not a hitting read-out, including a read-out that misses.
- R6: A byte write (wr_en=1, rd_en=0, mem_rdy=0) that hits replaces only byte `off` of the hitting line with `cpu_wdata`. The other fifteen bytes keep their values.
- R7: A byte write that misses changes nothing: it allocates no line and changes no data.
- R8: A line fill (wr_en=1, rd_en=0, mem_rdy=1) that misses writes `fill_line` and the address tag into the way named by the replacement counter and sets that line valid.
- R9: The replacement counter is 0 after reset and advances by one modulo 4 at every rising edge. A fill at the k-th edge after reset release (k from 0) that misses uses way k mod 4.
- R10: A line fill that hits overwrites the way that already holds the tag, so no set ever holds the same tag twice.
- R11: Any other control combination (both enables high, or read enable with memory-ready) changes neither the stored lines nor `rd_data`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_en | input | 1 | Read enable from the sequencer |
| wr_en | input | 1 | Write enable from the sequencer |
| mem_rdy | input | 1 | Memory-side line is present on `fill_line` |
| addr | input | 12 | Byte address: tag, set index, byte offset |
| cpu_wdata | input | 8 | Processor byte for a byte write |
| fill_line | input | 128 | Whole line from the memory side for a fill |
| hit | output | 1 | A valid way at the indexed set holds the tag |
| hit_way | output | 2 | Number of the hitting way, 0 on a miss |
| rd_data | output | 8 | Byte latched by the last hitting read-out |

## Verification
The bench goes after four corner cases. The first is the lane arithmetic: a wrong offset-to-bit mapping would return a neighbour byte on read-out, or would spoil a neighbour lane on byte write. The second is the replacement counter's phase: if the counter were off by one cycle, back-to-back fills would land in the wrong ways, so an expected line would go missing and a line meant to stay would be evicted. The third is a fill onto a line that is already present: a design that always took the counter's way would hold the tag in two ways and would report the stale copy. The fourth is the set of illegal or missing-line control combinations, which must leave both the array and `rd_data` untouched; a design that decoded only one enable would write or reload on them.

// File: rtl/sa4_pkg.sv
package sa4_pkg;
  localparam int ADDR_W     = 12;
  localparam int OFF_W      = 4;
  localparam int IDX_W      = 4;
  localparam int WAY_W      = 2;
  localparam int BYTE_W     = 8;
  localparam int TAG_W      = ADDR_W - OFF_W - IDX_W;
  localparam int NWAYS      = 1 << WAY_W;
  localparam int NSETS      = 1 << IDX_W;
  localparam int LINE_BYTES = 1 << OFF_W;
  localparam int LINE_W     = LINE_BYTES * BYTE_W;

  typedef logic [ADDR_W-1:0] addr_t;
  typedef logic [OFF_W-1:0]  off_t;
  typedef logic [IDX_W-1:0]  idx_t;
  typedef logic [TAG_W-1:0]  tag_t;
  typedef logic [WAY_W-1:0]  way_t;
  typedef logic [BYTE_W-1:0] byte_t;
  typedef logic [LINE_W-1:0] line_t;

  // address field extraction
  function automatic off_t addr_off(addr_t a);
    return a[OFF_W-1:0];
  endfunction

  function automatic idx_t addr_idx(addr_t a);
    return a[OFF_W +: IDX_W];
  endfunction

  function automatic tag_t addr_tag(addr_t a);
    return a[ADDR_W-1 -: TAG_W];
  endfunction

  // byte lane k occupies bits [8k+7:8k]
  function automatic byte_t lane_get(line_t l, off_t o);
    return l[int'(o)*BYTE_W +: BYTE_W];
  endfunction

  function automatic line_t lane_put(line_t l, off_t o, byte_t b);
    line_t r;
    r = l;
    r[int'(o)*BYTE_W +: BYTE_W] = b;
    return r;
  endfunction
endpackage

// File: rtl/sa4_way.sv
module sa4_way
  import sa4_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  idx_t  idx,
  input  tag_t  tag,
  input  off_t  off,
  input  logic  byte_we,
  input  byte_t byte_d,
  input  logic  fill_we,
  input  line_t fill_d,
  output logic  match,
  output byte_t rd_byte
);
  logic [NSETS-1:0] vld_q;
  tag_t             tag_q [NSETS];
  line_t            dat_q [NSETS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= '0;
    else if (fill_we) vld_q[idx] <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (fill_we) begin
      tag_q[idx] <= tag;
      dat_q[idx] <= fill_d;
    end else if (byte_we) begin
      dat_q[idx] <= lane_put(dat_q[idx], off, byte_d);
    end
  end

  assign match   = vld_q[idx] && (tag_q[idx] == tag);
  assign rd_byte = lane_get(dat_q[idx], off);
endmodule

// File: rtl/sa4_victim_ctr.sv
module sa4_victim_ctr
  import sa4_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  output way_t victim
);
  way_t cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_q + way_t'(1);
  end

  assign victim = cnt_q;
endmodule

// File: rtl/sa4_hit_enc.sv
module sa4_hit_enc
  import sa4_pkg::*;
(
  input  logic [NWAYS-1:0] match,
  output logic             hit,
  output way_t             way
);
  always_comb begin
    hit = 1'b0;
    way = '0;
    for (int i = NWAYS - 1; i >= 0; i--) begin
      if (match[i]) begin
        hit = 1'b1;
        way = way_t'(i);
      end
    end
  end
endmodule

// File: rtl/sa4_cache_array.sv
module sa4_cache_array
  import sa4_pkg::*;
(
  input  logic         clk,
  input  logic         rst_n,
  input  logic         rd_en,
  input  logic         wr_en,
  input  logic         mem_rdy,
  input  logic [11:0]  addr,
  input  logic [7:0]   cpu_wdata,
  input  logic [127:0] fill_line,
  output logic         hit,
  output logic [1:0]   hit_way,
  output logic [7:0]   rd_data
);
  off_t             off;
  idx_t             idx;
  tag_t             tag;
  logic [NWAYS-1:0] way_match;
  byte_t            way_byte [NWAYS];
  way_t             victim;
  way_t             dst_way;
  logic             fill_evt;
  logic             bwr_evt;
  logic             rd_evt;
  byte_t            rd_q;

  assign off = addr_off(addr);
  assign idx = addr_idx(addr);
  assign tag = addr_tag(addr);

  // operation decode
  assign fill_evt = wr_en && !rd_en && mem_rdy;
  assign bwr_evt  = wr_en && !rd_en && !mem_rdy && hit;
  assign rd_evt   = rd_en && !wr_en && !mem_rdy;
  assign dst_way  = hit ? hit_way : victim;

  generate
    for (genvar w = 0; w < NWAYS; w++) begin : g_way
      sa4_way u_way (
        .clk     (clk),
        .rst_n   (rst_n),
        .idx     (idx),
        .tag     (tag),
        .off     (off),
        .byte_we (bwr_evt && (hit_way == way_t'(w))),
        .byte_d  (cpu_wdata),
        .fill_we (fill_evt && (dst_way == way_t'(w))),
        .fill_d  (fill_line),
        .match   (way_match[w]),
        .rd_byte (way_byte[w])
      );
    end
  endgenerate

  sa4_hit_enc u_enc (
    .match (way_match),
    .hit   (hit),
    .way   (hit_way)
  );

  sa4_victim_ctr u_ctr (
    .clk    (clk),
    .rst_n  (rst_n),
    .victim (victim)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             rd_q <= '0;
    else if (rd_evt && hit) rd_q <= way_byte[hit_way];
  end

  assign rd_data = rd_q;
endmodule

// File: rtl/sa4_cache_array_chk.sv
module sa4_cache_array_chk
  import sa4_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic [11:0]      addr,
  input logic             hit,
  input logic [1:0]       hit_way,
  input logic [7:0]       rd_data,
  input logic [NWAYS-1:0] way_match,
  input logic             fill_evt,
  input logic             rd_evt,
  input way_t             victim,
  input way_t             dst_way
);
  // R10: a tag is never held twice in one set
  p_single_match_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(way_match));

  // R2: miss reports way 0, hit names a matching way
  p_miss_way_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !hit |-> (hit_way == 2'd0));
  p_hit_way_r2: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> way_match[hit_way]);

  // R9: counter steps by one every edge
  p_ctr_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (victim == way_t'($past(victim) + way_t'(1))));

  // R8: a filled line is found in its destination way next cycle
  p_fill_hit_r8: assert property (@(posedge clk) disable iff (!rst_n)
    fill_evt |=> (($past(addr) != addr) || (hit && (hit_way == $past(dst_way)))));

  // R5: rd_data moves only on a hitting read-out
  p_rd_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_evt && hit) |=> $stable(rd_data));
endmodule

bind sa4_cache_array sa4_cache_array_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .addr      (addr),
  .hit       (hit),
  .hit_way   (hit_way),
  .rd_data   (rd_data),
  .way_match (way_match),
  .fill_evt  (fill_evt),
  .rd_evt    (rd_evt),
  .victim    (victim),
  .dst_way   (dst_way)
);

// File: tb/sim_sa4_cache_array.sv
`timescale 1ns/1ps
module sim_sa4_cache_array;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         rd_en = 1'b0, wr_en = 1'b0, mem_rdy = 1'b0;
  logic [11:0]  addr = '0;
  logic [7:0]   cpu_wdata = '0;
  logic [127:0] fill_line = '0;
  logic         hit;
  logic [1:0]   hit_way;
  logic [7:0]   rd_data;

  always #2.5 clk = ~clk;

  sa4_cache_array u0 (
    .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .wr_en(wr_en), .mem_rdy(mem_rdy),
    .addr(addr), .cpu_wdata(cpu_wdata), .fill_line(fill_line),
    .hit(hit), .hit_way(hit_way), .rd_data(rd_data)
  );

  int n_chk = 0;
  int n_err = 0;
  bit cmp_on = 1'b0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // behavioural reference model
  bit         m_vld [4][16];
  int         m_tag [4][16];
  logic [7:0] m_dat [4][16][16];
  int         m_ctr;
  logic [7:0] m_rd;
  int         m_last_fill;

  function automatic int m_look(logic [11:0] a);
    for (int w = 0; w < 4; w++)
      if (m_vld[w][a[7:4]] && m_tag[w][a[7:4]] == int'(a[11:8])) return w;
    return -1;
  endfunction

  always @(posedge clk or negedge rst_n) begin : mdl
    int w, d;
    if (!rst_n) begin
      for (int i = 0; i < 4; i++)
        for (int s = 0; s < 16; s++) m_vld[i][s] = 1'b0;
      m_ctr = 0;
      m_rd = 8'h00;
      m_last_fill = -1;
    end else begin
      w = m_look(addr);
      if (wr_en && !rd_en && mem_rdy) begin
        d = (w >= 0) ? w : m_ctr;
        m_vld[d][addr[7:4]] = 1'b1;
        m_tag[d][addr[7:4]] = int'(addr[11:8]);
        for (int k = 0; k < 16; k++) m_dat[d][addr[7:4]][k] = fill_line[8*k +: 8];
        m_last_fill = d;
      end else if (wr_en && !rd_en && !mem_rdy && w >= 0) begin
        m_dat[w][addr[7:4]][addr[3:0]] = cpu_wdata;
      end else if (rd_en && !wr_en && !mem_rdy && w >= 0) begin
        m_rd = m_dat[w][addr[7:4]][addr[3:0]];
      end
      m_ctr = (m_ctr + 1) % 4;
    end
  end

  // per-cycle comparison away from the active edge
  always @(negedge clk) begin : cmp
    int w;
    if (rst_n && cmp_on) begin
      w = m_look(addr);
      chk(hit === (w >= 0), "R2 hit flag", int'(hit), int'(w >= 0));
      chk(hit_way === ((w >= 0) ? 2'(w) : 2'd0), "R2 hit_way", int'(hit_way), (w >= 0) ? w : 0);
      chk(rd_data === m_rd, "R4 rd_data", int'(rd_data), int'(m_rd));
    end
  end

  task automatic step(input bit r, input bit w, input bit y, input logic [11:0] a,
                      input logic [7:0] d, input logic [127:0] l);
    @(posedge clk);
    #1;
    rd_en = r; wr_en = w; mem_rdy = y; addr = a; cpu_wdata = d; fill_line = l;
  endtask

  task automatic look(input logic [11:0] a);
    step(1'b0, 1'b0, 1'b0, a, 8'h00, '0);
    @(negedge clk);
  endtask

  function automatic logic [127:0] mkline(input logic [7:0] seed);
    logic [127:0] r;
    for (int k = 0; k < 16; k++) r[8*k +: 8] = seed + 8'(k * 17);
    return r;
  endfunction

  initial begin : wdog
    #(200000 * 5);
    n_err++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin : main
    logic [127:0] l1, l2;
    int w_first, w4, w5, w6, w7;
    logic [7:0] keep;
    l1 = mkline(8'h10);
    l2 = mkline(8'h83);
    #12 rst_n = 1'b1;
    @(negedge clk);
    // R3: everything misses after reset, R5: rd_data starts at 0
    chk(hit === 1'b0, "R3 miss after reset", int'(hit), 0);
    look(12'h125);
    chk(hit === 1'b0, "R3 miss after reset", int'(hit), 0);
    chk(rd_data === 8'h00, "R5 rd_data reset", int'(rd_data), 0);
    cmp_on = 1'b1;

    // R8: fill a missing line
    step(1'b0, 1'b1, 1'b1, 12'h125, 8'h00, l1);
    look(12'h125);
    chk(hit === 1'b1 && int'(hit_way) == m_last_fill, "R8 fill lands in victim", int'(hit_way), m_last_fill);
    w_first = int'(hit_way);

    // R4: read-out of offset 5 and offset 1
    step(1'b1, 1'b0, 1'b0, 12'h125, 8'h00, '0);
    look(12'h125);
    chk(rd_data === l1[47:40], "R4 offset 5 byte", int'(rd_data), int'(l1[47:40]));
    step(1'b1, 1'b0, 1'b0, 12'h121, 8'h00, '0);
    look(12'h121);
    chk(rd_data === l1[15:8], "R4 offset 1 byte", int'(rd_data), int'(l1[15:8]));

    // R1: other tag or other index misses
    look(12'h325);
    chk(hit === 1'b0, "R1 other tag misses", int'(hit), 0);
    look(12'h135);
    chk(hit === 1'b0, "R1 other index misses", int'(hit), 0);

    // R6: byte write hit touches one lane
    step(1'b0, 1'b1, 1'b0, 12'h12A, 8'hD4, '0);
    step(1'b1, 1'b0, 1'b0, 12'h12A, 8'h00, '0);
    look(12'h12A);
    chk(rd_data === 8'hD4, "R6 written lane", int'(rd_data), 'hD4);
    step(1'b1, 1'b0, 1'b0, 12'h129, 8'h00, '0);
    look(12'h129);
    chk(rd_data === l1[79:72], "R6 neighbour lane kept", int'(rd_data), int'(l1[79:72]));

    // R7: byte write miss allocates nothing; R5: miss read-out holds
    step(1'b0, 1'b1, 1'b0, 12'h32A, 8'h3F, '0);
    look(12'h32A);
    chk(hit === 1'b0, "R7 write miss no allocate", int'(hit), 0);
    keep = rd_data;
    step(1'b1, 1'b0, 1'b0, 12'h32A, 8'h00, '0);
    look(12'h32A);
    chk(rd_data === keep, "R5 miss read-out holds", int'(rd_data), int'(keep));

    // R10: fill onto a present line reuses its way
    step(1'b0, 1'b1, 1'b1, 12'h120, 8'h00, l2);
    step(1'b1, 1'b0, 1'b0, 12'h120, 8'h00, '0);
    look(12'h120);
    chk(hit === 1'b1 && int'(hit_way) == w_first, "R10 refill same way", int'(hit_way), w_first);
    chk(rd_data === l2[7:0], "R10 refreshed data", int'(rd_data), int'(l2[7:0]));

    // R9: four back-to-back fills take consecutive ways
    step(1'b0, 1'b1, 1'b1, 12'h420, 8'h00, mkline(8'h40));
    step(1'b0, 1'b1, 1'b1, 12'h520, 8'h00, mkline(8'h50));
    step(1'b0, 1'b1, 1'b1, 12'h620, 8'h00, mkline(8'h60));
    step(1'b0, 1'b1, 1'b1, 12'h720, 8'h00, mkline(8'h70));
    look(12'h420); w4 = int'(hit_way);
    look(12'h520); w5 = int'(hit_way);
    look(12'h620); w6 = int'(hit_way);
    look(12'h720); w7 = int'(hit_way);
    chk(w5 == (w4 + 1) % 4, "R9 consecutive victim", w5, (w4 + 1) % 4);
    chk(w6 == (w4 + 2) % 4, "R9 consecutive victim", w6, (w4 + 2) % 4);
    chk(w7 == (w4 + 3) % 4, "R9 consecutive victim", w7, (w4 + 3) % 4);
    look(12'h120);
    chk(hit === 1'b0, "R9 old line evicted", int'(hit), 0);

    // R11: illegal combinations change nothing
    step(1'b1, 1'b1, 1'b1, 12'h7A0, 8'h55, mkline(8'hEE));
    look(12'h7A0);
    chk(hit === 1'b0, "R11 both enables no fill", int'(hit), 0);
    keep = rd_data;
    step(1'b1, 1'b0, 1'b1, 12'h427, 8'h00, '0);
    look(12'h427);
    chk(rd_data === keep, "R11 read with mem_rdy ignored", int'(rd_data), int'(keep));
    step(1'b1, 1'b1, 1'b0, 12'h427, 8'hAA, '0);
    step(1'b1, 1'b0, 1'b0, 12'h427, 8'h00, '0);
    look(12'h427);
    chk(rd_data === (8'h40 + 8'(7 * 17)), "R11 byte lane untouched", int'(rd_data), int'(8'h40 + 8'(7 * 17)));

    // mixed traffic against the model
    for (int i = 0; i < 400; i++) begin
      int op;
      logic [11:0] a;
      op = int'($urandom_range(0, 5));
      a = {2'b00, 2'($urandom_range(0, 3)), 3'b000, 1'($urandom_range(0, 1)), 4'($urandom_range(0, 15))};
      case (op)
        0: step(1'b0, 1'b1, 1'b1, a, 8'h00, {$urandom, $urandom, $urandom, $urandom});
        1, 2: step(1'b1, 1'b0, 1'b0, a, 8'h00, '0);
        3: step(1'b0, 1'b1, 1'b0, a, 8'($urandom), '0);
        4: step(1'b1, 1'b1, 1'($urandom), a, 8'($urandom), '1);
        default: step(1'b0, 1'b0, 1'b0, a, 8'h00, '0);
      endcase
    end
    look(12'h000);
    cmp_on = 1'b0;
    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule